// File: doc/BRIEF.md
# Iterative 64/32 Integer Divider with Status Flags

This block divides a 64-bit dividend by a 32-bit divisor for a 32-bit processor datapath. The dividend is the concatenation of a high-word register (upper half) and a low data register (lower half). The unit returns a 32-bit quotient meant for the low data register and a 32-bit remainder meant for the high-word register. It also produces four status flags: zero, negative, carry and overflow. A mode input chooses between two's-complement and unsigned operation.

An operation begins with a one-cycle `start` while the unit is idle. A nonzero divisor runs a shift-subtract loop of 2*W steps, with `busy` high throughout, and then a single-cycle `done`. A zero divisor never traps. It finishes on the cycle after `start` and returns a fixed result: the low result is 0xFF, the high result is the low dividend word, and overflow is set. Results and flags hold their values until the next completion.

Top module: `div64_unit`

## Requirements
- R1: In unsigned mode (`signed_mode`=0) with a nonzero divisor, `lo_out` is the low 32 bits of {hi_in,lo_in} / divisor_in and `hi_out` is the remainder.
- R2: In signed mode (`signed_mode`=1) all operands are two's complement. The quotient truncates toward zero and the remainder carries the sign of the 64-bit dividend.
- R3: A quotient wider than 32 bits is cut to its low 32 bits and leaves `flag_v` at 0.
- R4: A zero divisor makes `done` rise on the cycle after `start`, with `lo_out`=0x000000FF, `hi_out`=lo_in and `flag_v`=1, in either mode.
- R5: At every completion, `flag_z` is 1 exactly when `lo_out` is 0, and `flag_n` equals bit 31 of `lo_out`. This holds for zero divisors too.
- R6: `flag_c` is 0 after every completion. `flag_v` is 1 only after a zero-divisor operation.
- R7: With a nonzero divisor, `busy` is 1 from the cycle after `start` until `done`. `done` rises exactly 2*W+1 = 65 clock edges after the start edge, and `busy` is 0 whenever `done` is 1.
- R8: A `start` that arrives while `busy` is 1 is ignored. The running operation's result and latency are unchanged.
- R9: After synchronous active-low reset, `busy`, `done`, both result words and all four flags are 0.
- R10: Results and flags change only on a completion, and stay stable on every cycle where `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| signed_mode | input | 1 | 1 = two's complement, 0 = unsigned |
| hi_in | input | 32 | Dividend bits 63:32 |
| lo_in | input | 32 | Dividend bits 31:0 |
| divisor_in | input | 32 | Divisor |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion strobe |
| lo_out | output | 32 | Quotient (0xFF on a zero divisor) |
| hi_out | output | 32 | Remainder (low dividend word on a zero divisor) |
| flag_z | output | 1 | Low result is zero |
| flag_n | output | 1 | Bit 31 of low result |
| flag_c | output | 1 | Carry, always cleared |
| flag_v | output | 1 | Zero divisor seen |

## Verification
The assertions check these properties on every cycle:
- The zero-divisor result appears one cycle after an accepted start.
- `flag_z` and `flag_n` agree with `lo_out` whenever `done` is high.
- The results stay stable while `done` is low.
- `busy` and `done` never overlap, and `busy` persists until completion.
- The partial remainder in the loop stays below the divisor.

Only the bench scenarios can show whether the quotient and remainder values are arithmetically correct, including sign handling and truncation of wide quotients. The same holds for the exact 65-edge latency and for a mid-operation start being discarded.

// File: rtl/div_pkg.sv
// Package div_pkg
// Shared types for the divider. Assumes a flag set of four status bits.
package div_pkg;

    // Status flags produced at each completion
    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } div_flags_t;

    localparam div_flags_t FLAGS_CLEAR = '{z: 1'b0, n: 1'b0, c: 1'b0, v: 1'b0};

endpackage

// File: rtl/div_operand_prep.sv
// Module div_operand_prep
// Turns the raw operands into magnitudes and sign decisions for an
// unsigned core. Assumes the dividend is {hi, lo}. In signed mode the
// top bit of each operand is its sign. Purely combinational.
module div_operand_prep #(
    parameter int W = 32
) (
    input  logic           signed_mode,
    input  logic [W-1:0]   hi,
    input  logic [W-1:0]   lo,
    input  logic [W-1:0]   divisor,
    output logic [2*W-1:0] dvd_mag,
    output logic [W-1:0]   dvs_mag,
    output logic           q_neg,
    output logic           r_neg,
    output logic           dvs_zero
);
    localparam int DW = 2 * W;

    logic [DW-1:0] dvd_raw;
    logic          dvd_neg;
    logic          dvs_neg;

    // Derive operand signs, magnitudes and result-sign decisions
    always_comb begin
        dvd_raw  = {hi, lo};
        dvd_neg  = signed_mode & hi[W-1];
        dvs_neg  = signed_mode & divisor[W-1];
        dvd_mag  = dvd_neg ? (~dvd_raw + DW'(1)) : dvd_raw;
        dvs_mag  = dvs_neg ? (~divisor + W'(1)) : divisor;
        q_neg    = dvd_neg ^ dvs_neg;
        r_neg    = dvd_neg;
        dvs_zero = (divisor == '0);
    end
endmodule

// File: rtl/div_shift_core.sv
// Module div_shift_core
// Unsigned restoring shift-subtract divider: 2*W-bit dividend by W-bit
// divisor, one quotient bit per cycle, 2*W cycles per operation.
// Assumes load is never given with a zero divisor or while busy.
// Pulses fin for one cycle after the final step.
module div_shift_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [2*W-1:0] dvd_mag,
    input  logic [W-1:0]   dvs_mag,
    output logic           busy,
    output logic           fin,
    output logic [W-1:0]   quot_lo,
    output logic [W-1:0]   rem
);
    localparam int DW    = 2 * W;
    localparam int STEPS = DW;
    localparam int CNT_W = $clog2(STEPS);

    logic [W-1:0]     rem_q;
    logic [DW-1:0]    qreg_q;
    logic [W-1:0]     dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             fin_q;

    logic [W:0]       shifted;
    logic [W:0]       diff;
    logic             ge;
    logic [W-1:0]     rem_nxt;
    logic [DW-1:0]    qreg_nxt;

    // One restoring step: shift in the next dividend bit, try subtracting
    always_comb begin
        shifted  = {rem_q, qreg_q[DW-1]};
        diff     = shifted - {1'b0, dvs_q};
        ge       = (shifted >= {1'b0, dvs_q});
        rem_nxt  = ge ? diff[W-1:0] : shifted[W-1:0];
        qreg_nxt = {qreg_q[DW-2:0], ge};
    end

    // Sequencer: load operands, then iterate STEPS times and flag finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            qreg_q <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load) begin
                rem_q  <= '0;
                qreg_q <= dvd_mag;
                dvs_q  <= dvs_mag;
                cnt_q  <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q  <= rem_nxt;
                qreg_q <= qreg_nxt;
                cnt_q  <= cnt_q + CNT_W'(1);
                if (cnt_q == CNT_W'(STEPS - 1)) begin
                    busy_q <= 1'b0;
                    fin_q  <= 1'b1;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign fin     = fin_q;
    assign quot_lo = qreg_q[W-1:0];
    assign rem     = rem_q;

    // R1: the partial remainder never reaches the divisor during iteration
    a_r1_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (rem_q < dvs_q));

    // R7: finish is never flagged while the loop still runs
    a_r7_fin_after_loop: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |-> !busy_q);

    // R7: finish follows the cycle in which the loop was still busy
    a_r7_fin_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |-> $past(busy_q));
endmodule

// File: rtl/div_result_fix.sv
// Module div_result_fix
// Applies result signs, substitutes the zero-divisor convention and
// derives the flags from the final low result. Combinational; assumes
// quot_lo/rem are unsigned magnitudes from the core.
module div_result_fix
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         zero_div,
    input  logic         q_neg,
    input  logic         r_neg,
    input  logic [W-1:0] quot_lo,
    input  logic [W-1:0] rem,
    input  logic [W-1:0] dvd_lo,
    output logic [W-1:0] lo_res,
    output logic [W-1:0] hi_res,
    output div_flags_t   flags
);
    localparam logic [W-1:0] ZDIV_LO = W'(8'hFF);

    // Select final words and compute flags from the low result
    always_comb begin
        if (zero_div) begin
            lo_res = ZDIV_LO;
            hi_res = dvd_lo;
        end else begin
            lo_res = q_neg ? (~quot_lo + W'(1)) : quot_lo;
            hi_res = r_neg ? (~rem + W'(1)) : rem;
        end
        flags   = FLAGS_CLEAR;
        flags.z = (lo_res == '0);
        flags.n = lo_res[W-1];
        flags.v = zero_div;
    end
endmodule

// File: rtl/div64_unit.sv
// Module div64_unit
// Top of the 64/32 divider: start/busy/done handshake, operand
// preparation, iterative core and registered results and flags.
// Assumes start is a level sampled each edge; it is taken only when idle.
module div64_unit
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] hi_in,
    input  logic [W-1:0] lo_in,
    input  logic [W-1:0] divisor_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] lo_out,
    output logic [W-1:0] hi_out,
    output logic         flag_z,
    output logic         flag_n,
    output logic         flag_c,
    output logic         flag_v
);
    localparam int DW = 2 * W;

    logic [DW-1:0] dvd_mag;
    logic [W-1:0]  dvs_mag;
    logic          q_neg_c, r_neg_c, dvs_zero;
    logic          q_neg_q, r_neg_q;
    logic          accept, load_core, zero_now, update;
    logic          core_busy, core_fin;
    logic [W-1:0]  core_quot, core_rem;
    logic [W-1:0]  lo_res, hi_res;
    div_flags_t    flags_res;

    logic          busy_q, done_q;
    logic [W-1:0]  lo_q, hi_q;
    div_flags_t    flags_q;

    div_operand_prep #(.W(W)) u_prep (
        .signed_mode (signed_mode),
        .hi          (hi_in),
        .lo          (lo_in),
        .divisor     (divisor_in),
        .dvd_mag     (dvd_mag),
        .dvs_mag     (dvs_mag),
        .q_neg       (q_neg_c),
        .r_neg       (r_neg_c),
        .dvs_zero    (dvs_zero)
    );

    // Handshake decode: accept when idle, split zero-divisor fast path
    always_comb begin
        accept    = start & ~busy_q;
        zero_now  = accept & dvs_zero;
        load_core = accept & ~dvs_zero;
        update    = zero_now | core_fin;
    end

    div_shift_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_core),
        .dvd_mag (dvd_mag),
        .dvs_mag (dvs_mag),
        .busy    (core_busy),
        .fin     (core_fin),
        .quot_lo (core_quot),
        .rem     (core_rem)
    );

    div_result_fix #(.W(W)) u_fix (
        .zero_div (zero_now),
        .q_neg    (q_neg_q),
        .r_neg    (r_neg_q),
        .quot_lo  (core_quot),
        .rem      (core_rem),
        .dvd_lo   (lo_in),
        .lo_res   (lo_res),
        .hi_res   (hi_res),
        .flags    (flags_res)
    );

    // Handshake state and captured result signs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            q_neg_q <= 1'b0;
            r_neg_q <= 1'b0;
        end else begin
            done_q <= update;
            if (load_core) begin
                busy_q  <= 1'b1;
                q_neg_q <= q_neg_c;
                r_neg_q <= r_neg_c;
            end else if (core_fin) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Result and flag registers, written only on a completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            flags_q <= FLAGS_CLEAR;
        end else if (update) begin
            lo_q    <= lo_res;
            hi_q    <= hi_res;
            flags_q <= flags_res;
        end
    end

    assign busy   = busy_q;
    assign done   = done_q;
    assign lo_out = lo_q;
    assign hi_out = hi_q;
    assign flag_z = flags_q.z;
    assign flag_n = flags_q.n;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;

    // R4: zero divisor completes on the next cycle with the fixed result
    a_r4_zero_div_result: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor_in == '0) |=>
        (done && lo_out == W'(8'hFF) && hi_out == $past(lo_in) && flag_v));

    // R5: zero and negative flags agree with the low result at completion
    a_r5_flags_track_lo: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_z == (lo_out == '0)) && (flag_n == lo_out[W-1]));

    // R7: busy and done never overlap
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7, R8: the top-level busy persists while the core still iterates
    a_r8_busy_until_fin: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && core_busy) |=> busy);

    // R10: results and flags are stable whenever no completion is shown
    a_r10_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(lo_out) && $stable(hi_out) && $stable(flags_q)));
endmodule

// File: tb/div64_unit_bench.sv
// Bench for div64_unit: table-driven operations followed by directed tests.
module div64_unit_bench;
    localparam int W       = 32;
    localparam int LATENCY = 2 * W + 1;
    localparam int NV      = 12;

    // Vector encoding: {signed_mode, hi, lo, divisor}
    localparam logic [96:0] VEC [NV] = '{
        {1'b0, 32'h0000_0000, 32'h0000_0064, 32'h0000_0007},
        {1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001},
        {1'b0, 32'h0000_0005, 32'h0000_0000, 32'h0000_0002},
        {1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0005},
        {1'b1, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'h0000_0007},
        {1'b1, 32'h0000_0000, 32'h0000_0064, 32'hFFFF_FFF9},
        {1'b1, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'hFFFF_FFF9},
        {1'b1, 32'h0000_0000, 32'h8000_0000, 32'hFFFF_FFFF},
        {1'b0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h8000_0001},
        {1'b1, 32'h1234_5678, 32'h9ABC_DEF0, 32'hFFFF_0000},
        {1'b0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {1'b1, 32'h4000_0000, 32'h0000_0000, 32'h0000_0003}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] hi_in = '0, lo_in = '0, divisor_in = '0;
    logic         busy, done;
    logic [W-1:0] lo_out, hi_out;
    logic         flag_z, flag_n, flag_c, flag_v;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    div64_unit #(.W(W)) u_div64_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .hi_in(hi_in), .lo_in(lo_in), .divisor_in(divisor_in),
        .busy(busy), .done(done), .lo_out(lo_out), .hi_out(hi_out),
        .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model computed from R1..R4
    task automatic model(input logic m, input logic [31:0] hi, input logic [31:0] lo,
                         input logic [31:0] dv, output logic [31:0] elo,
                         output logic [31:0] ehi, output logic ev);
        logic [63:0] un, uq, ur;
        longint      sn, sd, sq, sr;
        if (dv == 0) begin
            elo = 32'h0000_00FF; ehi = lo; ev = 1'b1;
        end else if (!m) begin
            un = {hi, lo};
            uq = un / {32'h0, dv};
            ur = un % {32'h0, dv};
            elo = uq[31:0]; ehi = ur[31:0]; ev = 1'b0;
        end else begin
            sn = longint'({hi, lo});
            sd = longint'(signed'(dv));
            sq = sn / sd;
            sr = sn % sd;
            elo = sq[31:0]; ehi = sr[31:0]; ev = 1'b0;
        end
    endtask

    // Issue one operation; return edges from the start edge until done
    task automatic issue(input logic m, input logic [31:0] hi, input logic [31:0] lo,
                         input logic [31:0] dv, output int lat, output logic busy_first);
        signed_mode = m; hi_in = hi; lo_in = lo; divisor_in = dv; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        busy_first = busy;
        lat = 0;
        while (!done && lat < 300) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_result(input logic m, input logic [31:0] hi, input logic [31:0] lo,
                                input logic [31:0] dv, input string tag);
        logic [31:0] elo, ehi;
        logic        ev;
        model(m, hi, lo, dv, elo, ehi, ev);
        chk(lo_out == elo, {tag, " lo_out"}, 64'(lo_out), 64'(elo));
        chk(hi_out == ehi, {tag, " hi_out"}, 64'(hi_out), 64'(ehi));
        chk(flag_v == ev, "R6/R3 flag_v", 64'(flag_v), 64'(ev));
        chk(flag_z == (elo == 0), "R5 flag_z", 64'(flag_z), 64'(elo == 0));
        chk(flag_n == elo[31], "R5 flag_n", 64'(flag_n), 64'(elo[31]));
        chk(flag_c == 1'b0, "R6 flag_c", 64'(flag_c), 64'd0);
        chk(busy == 1'b0, "R7 busy low at done", 64'(busy), 64'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int          lat;
        logic        bf;
        logic [31:0] keep_lo, keep_hi;

        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 0 && done == 0, "R9 busy/done", {busy, done}, 0);
        chk(lo_out == 0 && hi_out == 0, "R9 results", {lo_out, hi_out}, 0);
        chk({flag_z, flag_n, flag_c, flag_v} == 0, "R9 flags",
            {flag_z, flag_n, flag_c, flag_v}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2, R3: table walk
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], lat, bf);
            chk(lat == LATENCY, "R7 latency", 64'(lat), 64'(LATENCY));
            chk(bf == 1'b1, "R7 busy after start", 64'(bf), 64'd1);
            check_result(VEC[i][96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0],
                         VEC[i][96] ? "R2 signed" : "R1 unsigned");
            @(negedge clk);
            chk(done == 1'b0, "R7 done one cycle", 64'(done), 64'd0);
        end

        // R3: wide quotient truncated, no overflow
        issue(1'b0, 32'h0000_0005, 32'h0000_0000, 32'h0000_0002, lat, bf);
        chk(lo_out == 32'h8000_0000 && flag_v == 0, "R3 truncate",
            {lo_out, 31'b0, flag_v}, {32'h8000_0000, 32'h0});

        // R4: zero divisor in both modes, single cycle
        issue(1'b0, 32'hAAAA_0000, 32'h0000_1234, 32'h0, lat, bf);
        chk(lat == 0, "R4 one-cycle latency", 64'(lat), 64'd0);
        chk(bf == 1'b0, "R4 no busy", 64'(bf), 64'd0);
        check_result(1'b0, 32'hAAAA_0000, 32'h0000_1234, 32'h0, "R4 zero div u");
        @(negedge clk);
        issue(1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0, lat, bf);
        chk(lat == 0, "R4 one-cycle latency signed", 64'(lat), 64'd0);
        check_result(1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0, "R4 zero div s");
        @(negedge clk);

        // R8: start while busy is ignored
        signed_mode = 0; hi_in = 0; lo_in = 32'd1000; divisor_in = 32'd10; start = 1;
        @(posedge clk);
        @(negedge clk);
        start = 0;
        repeat (10) @(negedge clk);
        lo_in = 32'd77; divisor_in = 32'd0; start = 1;
        @(negedge clk);
        start = 0;
        lat = 11;
        while (!done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == LATENCY, "R8 latency unchanged", 64'(lat), 64'(LATENCY));
        chk(lo_out == 32'd100 && hi_out == 0, "R8 first result kept",
            {lo_out, hi_out}, {32'd100, 32'd0});

        // R10: outputs hold with changing inputs and no start
        keep_lo = lo_out; keep_hi = hi_out;
        hi_in = 32'h5555_5555; lo_in = 32'h3333_3333; divisor_in = 32'h9;
        repeat (8) @(negedge clk);
        chk(lo_out == keep_lo && hi_out == keep_hi && done == 0, "R10 hold",
            {lo_out, hi_out}, {keep_lo, keep_hi});

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule